// File: doc/BRIEF.md
# Windowed On-Chip RAM Controller

This block sits between a processor's 24-bit address bus and a 16-bit internal RAM of 8 KiB. It steers every access either to that RAM or to an off-chip request port. The RAM answers only inside a fixed address window, and only while a RAM-enable bit in an 8-bit system control register is set. Everything else goes off chip: addresses outside the window, and window addresses while the RAM is disabled.

Data lanes are big-endian. The byte at an even address lives in the high half of a stored word, and the byte at the following odd address lives in the low half. Byte and word accesses each take one clock. A word access at an odd address is refused and raises an address-error strobe.

The control register has its own byte address outside the window. A standby input freezes the block. While it is high, no access is taken and the register keeps its value. Only reset brings the register back to its initial value.

Top module: `ramwin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the control register reads 0x01: RAM enable (bit 0) is 1 and bits 7..3 are 0. All strobes (rd_valid, ext_req, addr_err) are low while reset is asserted.
- R2: The control register sits at byte address 0xFFFF39. A byte write there stores req_wdata[7:0], except that bits 2 and 1 always read 0. A byte read there returns the register in rd_data[7:0] with rd_data[15:8]=0, and asserts rd_valid one cycle after the request.
- R3: With bit 0 set, an aligned access to 0xFFDC00..0xFFFBFF inclusive is served by the internal RAM and not forwarded off chip. A read asserts rd_valid one cycle after the request. At most one of rd_valid, ext_req and addr_err is high in any cycle.
- R4: With bit 0 clear, an aligned access inside the window is forwarded off chip and leaves the RAM unchanged. Once bit 0 is set again, the earlier contents read back.
- R5: An aligned access outside the window, and not to the control address, is always forwarded off chip. One cycle after the request, ext_req is high for one cycle, and ext_addr, ext_write, ext_word and ext_wdata copy the request.
- R6: A word access (req_word=1) at an even address A moves 16 bits. Bits 15:8 are the byte at A and bits 7:0 are the byte at A+1. Word read data appears on rd_data one cycle after the request.
- R7: A byte write (req_word=0) takes its data from req_wdata[7:0]. At an even address it updates only bits 15:8 of the stored word. At an odd address it updates only bits 7:0. The other byte is unchanged.
- R8: A byte read from the RAM returns the selected byte in rd_data[7:0], with rd_data[15:8]=0.
- R9: A word access with req_addr[0]=1 is not performed. One cycle later addr_err is high for that cycle, with no ext_req and no rd_valid, and RAM and register contents are unchanged.
- R10: While standby_i is high, requests are ignored: no strobe rises one cycle later, and the control register keeps its value. It is reinitialized only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby: freeze, ignore requests |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rd_data | output | 16 | Read data for RAM or register reads |
| rd_valid | output | 1 | rd_data valid (one cycle after a read) |
| ext_req | output | 1 | Off-chip request strobe |
| ext_addr | output | 24 | Off-chip request address |
| ext_write | output | 1 | Off-chip request direction |
| ext_word | output | 1 | Off-chip request size |
| ext_wdata | output | 16 | Off-chip write data |
| addr_err | output | 1 | Misaligned word access strobe |

## Verification
Two functions can meet on consecutive edges: a register write that changes the RAM enable, and a window access issued in the very next cycle, which has to see the new routing. The same holds for a RAM write followed at once by a read of the same word, which has to return the merged bytes. The bench issues requests back to back with no idle cycles, so directed enable flips and random register writes land right before window accesses. Each outcome is judged against a bench model of the register and of every RAM word, which predicts the routing, the strobes and the read data.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;

    // where the read data of the previous cycle comes from
    typedef enum logic [1:0] {
        RD_WORD = 2'd0,
        RD_HI   = 2'd1,
        RD_LO   = 2'd2,
        RD_CTRL = 2'd3
    } rd_src_e;

    // routing decision for the current request
    typedef enum logic [2:0] {
        RT_NONE = 3'd0,
        RT_RAM  = 3'd1,
        RT_EXT  = 3'd2,
        RT_CTRL = 3'd3,
        RT_ERR  = 3'd4
    } route_e;

endpackage

// File: rtl/ramwin_decode.sv
module ramwin_decode
    import ramwin_pkg::*;
#(
    parameter int AW        = 24,
    parameter logic [AW-1:0] WIN_BASE  = 24'hFFDC00,
    parameter int WIN_BYTES = 8192,
    parameter logic [AW-1:0] CTRL_ADDR = 24'hFFFF39,
    parameter int IDX_W     = 12
) (
    input  logic          valid_i,
    input  logic          standby_i,
    input  logic [AW-1:0] addr_i,
    input  logic          word_i,
    input  logic          ram_en_i,
    output route_e        route_o,
    output logic [IDX_W-1:0] idx_o,
    output logic          odd_o
);
    localparam logic [AW-1:0] WIN_SIZE = AW'(WIN_BYTES);

    logic [AW-1:0] offset;
    logic          in_win;
    logic          misaligned;

    always_comb begin
        offset     = addr_i - WIN_BASE;
        in_win     = (addr_i >= WIN_BASE) && (offset < WIN_SIZE);
        misaligned = word_i && offset[0];
        idx_o      = offset[IDX_W:1];
        odd_o      = offset[0];

        if (!valid_i || standby_i) begin
            route_o = RT_NONE;
        end else if (misaligned) begin
            route_o = RT_ERR;
        end else if (addr_i == CTRL_ADDR) begin
            route_o = RT_CTRL;
        end else if (in_win && ram_en_i) begin
            route_o = RT_RAM;
        end else begin
            route_o = RT_EXT;
        end
    end

endmodule

// File: rtl/ramwin_lane.sv
module ramwin_lane #(
    parameter int IDX_W = 12,
    parameter int BW    = 8
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic             re_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [BW-1:0]    wdata_i,
    output logic [BW-1:0]    rdata_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[idx_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem[idx_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/ramwin_ctrl.sv
module ramwin_ctrl
    import ramwin_pkg::*;
#(
    parameter int AW        = 24,
    parameter logic [AW-1:0] WIN_BASE  = 24'hFFDC00,
    parameter int WIN_BYTES = 8192,
    parameter logic [AW-1:0] CTRL_ADDR = 24'hFFFF39
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_i,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [15:0]   req_wdata,
    output logic [15:0]   rd_data,
    output logic          rd_valid,
    output logic          ext_req,
    output logic [AW-1:0] ext_addr,
    output logic          ext_write,
    output logic          ext_word,
    output logic [15:0]   ext_wdata,
    output logic          addr_err
);
    localparam int BW       = 8;
    localparam int LANES    = 2;
    localparam int IDX_W    = $clog2(WIN_BYTES / LANES);
    localparam int EN_BIT   = 0;
    localparam logic [BW-1:0] SYS_INIT  = 8'h01;
    localparam logic [BW-1:0] SYS_WMASK = 8'hF9;

    typedef struct packed {
        logic [BW-1:0] sysreg;
        logic          rd_valid;
        rd_src_e       rd_src;
        logic          ext_req;
        logic [AW-1:0] ext_addr;
        logic          ext_write;
        logic          ext_word;
        logic [15:0]   ext_wdata;
        logic          addr_err;
    } state_t;

    localparam state_t ST_RST = '{
        sysreg:    SYS_INIT,
        rd_valid:  1'b0,
        rd_src:    RD_WORD,
        ext_req:   1'b0,
        ext_addr:  '0,
        ext_write: 1'b0,
        ext_word:  1'b0,
        ext_wdata: '0,
        addr_err:  1'b0
    };

    state_t st_d, st_q;

    route_e           route;
    logic [IDX_W-1:0] idx;
    logic             odd;
    logic             ram_en;
    logic [BW-1:0]    lane_rd [LANES];

    assign ram_en = st_q.sysreg[EN_BIT];

    ramwin_decode #(
        .AW        (AW),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES),
        .CTRL_ADDR (CTRL_ADDR),
        .IDX_W     (IDX_W)
    ) u_decode (
        .valid_i   (req_valid),
        .standby_i (standby_i),
        .addr_i    (req_addr),
        .word_i    (req_word),
        .ram_en_i  (ram_en),
        .route_o   (route),
        .idx_o     (idx),
        .odd_o     (odd)
    );

    // lane 1 holds even-address bytes (bits 15:8), lane 0 odd-address bytes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit IS_HIGH = (g == LANES - 1);
        logic          hit;
        logic          we;
        logic          re;
        logic [BW-1:0] wdata;

        always_comb begin
            hit   = req_word || (IS_HIGH ? !odd : odd);
            we    = (route == RT_RAM) && req_write && hit;
            re    = (route == RT_RAM) && !req_write;
            wdata = (req_word && IS_HIGH) ? req_wdata[15:8] : req_wdata[7:0];
        end

        ramwin_lane #(
            .IDX_W (IDX_W),
            .BW    (BW)
        ) u_lane (
            .clk     (clk),
            .we_i    (we),
            .re_i    (re),
            .idx_i   (idx),
            .wdata_i (wdata),
            .rdata_o (lane_rd[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.ext_req  = 1'b0;
        st_d.addr_err = 1'b0;

        unique case (route)
            RT_ERR: begin
                st_d.addr_err = 1'b1;
            end
            RT_CTRL: begin
                if (req_write) begin
                    st_d.sysreg = req_wdata[BW-1:0] & SYS_WMASK;
                end else begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_src   = RD_CTRL;
                end
            end
            RT_RAM: begin
                if (!req_write) begin
                    st_d.rd_valid = 1'b1;
                    if (req_word) begin
                        st_d.rd_src = RD_WORD;
                    end else if (odd) begin
                        st_d.rd_src = RD_LO;
                    end else begin
                        st_d.rd_src = RD_HI;
                    end
                end
            end
            RT_EXT: begin
                st_d.ext_req   = 1'b1;
                st_d.ext_addr  = req_addr;
                st_d.ext_write = req_write;
                st_d.ext_word  = req_word;
                st_d.ext_wdata = req_wdata;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.rd_src)
            RD_WORD: rd_data = {lane_rd[1], lane_rd[0]};
            RD_HI:   rd_data = {8'h00, lane_rd[1]};
            RD_LO:   rd_data = {8'h00, lane_rd[0]};
            default: rd_data = {8'h00, st_q.sysreg};
        endcase
    end

    assign rd_valid  = st_q.rd_valid;
    assign ext_req   = st_q.ext_req;
    assign ext_addr  = st_q.ext_addr;
    assign ext_write = st_q.ext_write;
    assign ext_word  = st_q.ext_word;
    assign ext_wdata = st_q.ext_wdata;
    assign addr_err  = st_q.addr_err;

endmodule

// File: rtl/ramwin_ctrl_chk.sv
module ramwin_ctrl_chk #(
    parameter int AW        = 24,
    parameter logic [AW-1:0] WIN_BASE  = 24'hFFDC00,
    parameter int WIN_BYTES = 8192,
    parameter logic [AW-1:0] CTRL_ADDR = 24'hFFFF39
) (
    input logic          clk,
    input logic          rst_n,
    input logic          standby_i,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_write,
    input logic          req_word,
    input logic [15:0]   rd_data,
    input logic          rd_valid,
    input logic          ext_req,
    input logic [AW-1:0] ext_addr,
    input logic          addr_err,
    input logic          ram_en
);
    localparam logic [AW-1:0] WIN_LAST = WIN_BASE + AW'(WIN_BYTES - 1);

    logic take, bad, in_win, is_ctrl;
    always_comb begin
        take    = req_valid && !standby_i;
        bad     = req_word && req_addr[0];
        in_win  = (req_addr >= WIN_BASE) && (req_addr <= WIN_LAST);
        is_ctrl = (req_addr == CTRL_ADDR);
    end

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, ext_req, addr_err}));

    assert_ram_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bad && in_win && ram_en && !req_write) |=> (rd_valid && !ext_req));

    assert_disabled_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bad && in_win && !ram_en) |=> (ext_req && !rd_valid));

    assert_outside_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bad && !in_win && !is_ctrl) |=> (ext_req && ext_addr == $past(req_addr)));

    assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_word && in_win && ram_en && !req_write) |=> (rd_data[15:8] == 8'h00));

    assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_ctrl && !req_word && !req_write) |=> (rd_valid && (rd_data & 16'hFF06) == 16'h0000));

    assert_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bad) |=> (addr_err && !ext_req && !rd_valid));

    assert_standby_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!rd_valid && !ext_req && !addr_err));

endmodule

bind ramwin_ctrl ramwin_ctrl_chk #(
    .AW        (AW),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_word  (req_word),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .ext_req   (ext_req),
    .ext_addr  (ext_addr),
    .addr_err  (addr_err),
    .ram_en    (ram_en)
);

// File: tb/ramwin_ctrl_bench.sv
`timescale 1ns/1ps
module ramwin_ctrl_bench;
    localparam logic [23:0] BASE = 24'hFFDC00;
    localparam logic [23:0] LAST = 24'hFFFBFF;
    localparam logic [23:0] CTRL = 24'hFFFF39;
    localparam int WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid, ext_req, ext_write, ext_word, addr_err;
    logic [23:0] ext_addr;
    logic [15:0] ext_wdata;

    int compared = 0;
    int mismatched = 0;

    logic [15:0] model [WORDS];
    logic [7:0]  m_sys = 8'h01;

    always #2.5 clk = ~clk;

    ramwin_ctrl u_ramwin_ctrl (
        .clk, .rst_n, .standby_i, .req_valid, .req_addr, .req_write, .req_word,
        .req_wdata, .rd_data, .rd_valid, .ext_req, .ext_addr, .ext_write,
        .ext_word, .ext_wdata, .addr_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit in_window(input logic [23:0] a);
        return (a >= BASE) && (a <= LAST);
    endfunction

    task automatic access(input logic [23:0] a, input logic w, input logic wd,
                          input logic [15:0] d, input string req);
        bit err, ctl, ram, ext;
        int idx;
        logic [15:0] exp_rd;
        err = wd && a[0];
        ctl = !err && (a == CTRL);
        ram = !err && !ctl && in_window(a) && m_sys[0];
        ext = !err && !ctl && !ram;
        idx = in_window(a) ? int'((a - BASE) >> 1) : 0;
        if (ctl) exp_rd = {8'h00, m_sys};
        else if (wd) exp_rd = model[idx];
        else if (a[0]) exp_rd = {8'h00, model[idx][7:0]};
        else exp_rd = {8'h00, model[idx][15:8]};

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_word = wd; req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk({req, " addr_err"}, 32'(addr_err), 32'(err));
        chk({req, " ext_req"}, 32'(ext_req), 32'(ext));
        chk({req, " rd_valid"}, 32'(rd_valid), 32'(!w && (ram || ctl)));
        if (!w && (ram || ctl)) chk({req, " rd_data"}, 32'(rd_data), 32'(exp_rd));
        if (ext) begin
            chk({req, " ext_addr"}, 32'(ext_addr), 32'(a));
            chk({req, " ext_ctl"}, {30'd0, ext_write, ext_word}, {30'd0, w, wd});
            chk({req, " ext_wdata"}, 32'(ext_wdata), 32'(d));
        end
        if (ctl && w) m_sys = d[7:0] & 8'hF9;
        if (ram && w) begin
            if (wd) model[idx] = d;
            else if (a[0]) model[idx][7:0] = d[7:0];
            else model[idx][15:8] = d[7:0];
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #750000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_2357));
        repeat (3) @(posedge clk);
        #1;
        // R1: strobes low in reset
        chk("R1 reset strobes", {29'd0, rd_valid, ext_req, addr_err}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        access(CTRL, 1'b0, 1'b0, 16'h0, "R1 reset value");

        // R2: masked bits
        access(CTRL, 1'b1, 1'b0, 16'h00FF, "R2 write");
        access(CTRL, 1'b0, 1'b0, 16'h0, "R2 read");
        access(CTRL, 1'b1, 1'b0, 16'h0001, "R2 restore");

        // R6: fill whole RAM by word writes
        for (int i = 0; i < WORDS; i++)
            access(BASE + 24'(2 * i), 1'b1, 1'b1, 16'($urandom), "R6 fill");
        // R3 window edges, R6 word read
        access(BASE, 1'b0, 1'b1, 16'h0, "R3 first word");
        access(LAST - 24'd1, 1'b0, 1'b1, 16'h0, "R3 last word");
        access(LAST, 1'b0, 1'b0, 16'h0, "R8 last byte");
        // R7 byte writes, back-to-back read-after-write
        access(BASE + 24'h10, 1'b1, 1'b0, 16'hAB5A, "R7 even byte");
        access(BASE + 24'h10, 1'b0, 1'b1, 16'h0, "R7 word after even");
        access(BASE + 24'h11, 1'b1, 1'b0, 16'hCDC3, "R7 odd byte");
        access(BASE + 24'h10, 1'b0, 1'b1, 16'h0, "R7 word after odd");
        access(BASE + 24'h11, 1'b0, 1'b0, 16'h0, "R8 odd byte read");
        access(BASE + 24'h10, 1'b0, 1'b0, 16'h0, "R8 even byte read");
        // R9 misaligned, no change
        access(BASE + 24'h21, 1'b1, 1'b1, 16'hDEAD, "R9 odd word write");
        access(BASE + 24'h20, 1'b0, 1'b1, 16'h0, "R9 word unchanged");
        access(BASE + 24'h22, 1'b0, 1'b1, 16'h0, "R9 next unchanged");
        access(CTRL, 1'b1, 1'b1, 16'h0000, "R9 odd word to ctrl");
        access(CTRL, 1'b0, 1'b0, 16'h0, "R9 ctrl unchanged");
        // R4 disable then window access next cycle
        access(CTRL, 1'b1, 1'b0, 16'h0000, "R4 disable");
        access(BASE + 24'h40, 1'b1, 1'b1, 16'h1234, "R4 fwd write");
        access(BASE + 24'h41, 1'b0, 1'b0, 16'h0, "R4 fwd read");
        access(CTRL, 1'b1, 1'b0, 16'h0001, "R4 enable");
        access(BASE + 24'h40, 1'b0, 1'b1, 16'h0, "R4 contents kept");
        // R5 outside window with both enable values
        access(24'h000100, 1'b1, 1'b1, 16'h0F0F, "R5 low");
        access(BASE - 24'd1, 1'b0, 1'b0, 16'h0, "R5 below");
        access(LAST + 24'd1, 1'b1, 1'b0, 16'h00EE, "R5 above");
        access(CTRL, 1'b1, 1'b0, 16'h0000, "R5 disable");
        access(CTRL - 24'd1, 1'b0, 1'b1, 16'h0, "R5 next to ctrl");
        access(24'h7FFFFE, 1'b1, 1'b1, 16'h5555, "R5 mid");
        access(CTRL, 1'b1, 1'b0, 16'h0001, "R5 enable");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [23:0] a;
            sel = int'($urandom % 100);
            if (sel < 60) a = BASE + 24'($urandom % 8192);
            else if (sel < 75) a = 24'($urandom);
            else if (sel < 88) a = (sel[0]) ? BASE + 24'($urandom % 4) - 24'd2
                                            : LAST + 24'($urandom % 4) - 24'd1;
            else a = CTRL;
            if (a == CTRL && ($urandom % 2) == 0)
                access(CTRL, 1'b1, 1'b0, {8'h00, 7'($urandom), 1'(($urandom % 6) != 0)}, "R2 random ctrl");
            else
                access(a, 1'($urandom), 1'($urandom), 16'($urandom), "R3 random");
        end

        // R10 standby
        access(CTRL, 1'b1, 1'b0, 16'h00F8, "R10 set reg");
        @(negedge clk);
        standby_i = 1'b1;
        req_valid = 1'b1; req_addr = CTRL; req_write = 1'b1; req_word = 1'b0; req_wdata = 16'h0001;
        @(posedge clk); #1;
        chk("R10 standby write idle", {29'd0, rd_valid, ext_req, addr_err}, 32'd0);
        @(negedge clk);
        req_addr = BASE; req_write = 1'b0; req_word = 1'b1;
        @(posedge clk); #1;
        chk("R10 standby read idle", {29'd0, rd_valid, ext_req, addr_err}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0; standby_i = 1'b0;
        access(CTRL, 1'b0, 1'b0, 16'h0, "R10 reg kept");
        // R1: reset reinitializes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_sys = 8'h01;
        access(CTRL, 1'b0, 1'b0, 16'h0, "R1 reinit");
        access(BASE + 24'h10, 1'b0, 1'b1, 16'h0, "R3 after reset");
        finish_run();
    end
endmodule